// File: doc/BRIEF.md
# Smart Card Interface Interrupt Controller

This block gathers the event indications of a smart card interface into one 8-bit status register and raises a single interrupt request towards the processor. Neighbouring logic (the card UART, its FIFOs, the timeout counters and the card-presence detector) supplies one-cycle strobes and a few status levels. Firmware reads the status register over a simple register bus to find out why the interrupt fired. It masks individual causes through an enable register that sits at a second address.

Most status bits are sticky and are cleared by reading the register. The receive-data bit is different. In normal operation it mirrors the receive FIFO's non-empty flag. In bypass mode it latches on a falling edge of the card I/O line. Card insertion, removal and fault events are captured in an always-on clock domain, so they are still recorded while the main interface clock is stopped. They reach the register through a synchronizer.

Top module: `card_irq_hub`

## Requirements
- R1: After reset the status register reads 0x00, the enable register reads 0x00 and `irq` is low.
- R2: A read of address 0 (`reg_sel`=1, `reg_wr`=0, `reg_addr`=0) returns the status value of that cycle and clears every sticky bit from the next clock edge. Bits 7, 6, 5, 3, 2, 1 and 0 are always sticky, and bit 4 is sticky in bypass mode.
- R3: When `bypass_mode`=0, status bit 4 equals `rx_fifo_nonempty` as sampled at the previous clock edge, and reads do not clear it.
- R4: When `bypass_mode`=1, status bit 4 is set by a falling edge of `io_line` (high in one cycle, low in the next) and ignores `rx_fifo_nonempty`.
- R5: Status bit 7 is set by `wait_tmo` when `sync_mode`=0 and by `len_term` when `sync_mode`=1. The strobe not selected by the mode has no effect.
- R6: Status bit 2 is set by `tx_byte_done` or `tx_chk_done`, except in a cycle where `t0_mode`, `brk_det_en` and `brk_at_end` are all 1.
- R7: Status bit 1 is set by `tx_brk` or `tx_undr`. Bit 0 is set by `rx_ovr` or `rx_par`. Bit 3 is set by `tx_empty` or `tx_full`. Bit 5 is set by `vcc_tmo`.
- R8: A write to address 1 loads the enable register, and a read of address 1 returns it. Writes to address 0 have no effect. `irq` is high exactly when some status bit and its enable bit are both 1.
- R9: An event strobe in the same cycle as a clearing read is not lost: its bit reads as 1 on the following read.
- R10: A single pulse of `card_ins`, `card_rem` or `card_fault` on `aon_clk` sets status bit 6 within six main clock cycles. This also holds when the pulse arrives while `clk` is stopped.
- R11: Strobe-driven bits become visible on `reg_rdata` one clock edge after the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main interface clock |
| rst_n | input | 1 | Active-low synchronous reset, main domain |
| aon_clk | input | 1 | Always-on clock for card events |
| aon_rst_n | input | 1 | Active-low synchronous reset, always-on domain |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 1 | 0 = status, 1 = enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sync_mode | input | 1 | Synchronous card mode select |
| bypass_mode | input | 1 | I/O bypass mode select |
| t0_mode | input | 1 | T=0 protocol active |
| brk_det_en | input | 1 | Break detection enabled |
| wait_tmo | input | 1 | Wait/answer timeout strobe |
| len_term | input | 1 | Length counter terminal-count strobe |
| vcc_tmo | input | 1 | Supply timer expiry strobe |
| rx_fifo_nonempty | input | 1 | Receive FIFO holds data (level) |
| io_line | input | 1 | Card I/O line, already synchronized |
| tx_empty | input | 1 | Transmit FIFO became empty |
| tx_full | input | 1 | Transmit FIFO became full |
| tx_byte_done | input | 1 | Data byte transmitted |
| tx_chk_done | input | 1 | Check byte transmitted |
| brk_at_end | input | 1 | Break seen at end of the byte |
| tx_brk | input | 1 | Break detected during transmit |
| tx_undr | input | 1 | Transmit underrun |
| rx_ovr | input | 1 | Receive overrun |
| rx_par | input | 1 | Receive parity error |
| card_ins | input | 1 | Card inserted (aon_clk domain) |
| card_rem | input | 1 | Card removed (aon_clk domain) |
| card_fault | input | 1 | Interface fault (aon_clk domain) |

## Verification
The bench goes after the clear rules. It reads the receive-data bit twice with the FIFO non-empty: a design that cleared it on read would return 0x00 the second time. It also pulses `rx_fifo_nonempty` in bypass mode, and a design that ignored the mode would show bit 4. It fires a strobe in the same cycle as a clearing read: a design that let the clear win would lose that event. It combines a transmitted byte with a break at the end of the byte, with and without break detection, so that unconditional byte-sent logic shows up as a wrong bit 2. It stops the main clock while a card event arrives: a design that captured card events in the main domain would never set bit 6.

// File: rtl/card_irq_pkg.sv
// Package: shared constants for the smart card interrupt controller.
// Assumes an 8-bit status register whose bit positions are fixed by the
// firmware view (MSB wait timeout down to LSB receive error).
package card_irq_pkg;
    localparam int ST_W    = 8;
    localparam int REG_AW  = 1;
    localparam int B_WAIT  = 7;
    localparam int B_CARD  = 6;
    localparam int B_VCC   = 5;
    localparam int B_RDAV  = 4;
    localparam int B_TXEV  = 3;
    localparam int B_SENT  = 2;
    localparam int B_TXER  = 1;
    localparam int B_RXER  = 0;
    localparam logic [REG_AW-1:0] A_STAT = 1'b0;
    localparam logic [REG_AW-1:0] A_EN   = 1'b1;
    localparam logic [ST_W-1:0] STICKY_FIFO = 8'hEF;
    localparam logic [ST_W-1:0] STICKY_BYP  = 8'hFF;
endpackage

// File: rtl/card_evt_sync.sv
// Module: card_evt_sync
// Records card insert/remove/fault pulses in the always-on domain as a
// toggle and hands them to the main domain through a flop chain, giving a
// one-cycle pulse there. Assumes events are spaced widely enough that two
// never toggle between main-domain samples, and that both resets are
// applied together.
module card_evt_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic aon_clk,
    input  logic aon_rst_n,
    input  logic ev_ins,
    input  logic ev_rem,
    input  logic ev_fault,
    input  logic clk,
    input  logic rst_n,
    output logic evt_pulse
);
    localparam int TOP = SYNC_STAGES - 1;

    logic                   tgl_q;
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    // Flip the toggle on any card event, always-on clock.
    always_ff @(posedge aon_clk) begin
        if (!aon_rst_n) tgl_q <= 1'b0;
        else            tgl_q <= tgl_q ^ (ev_ins | ev_rem | ev_fault);
    end

    // Carry the toggle through the synchronizer chain, main clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[TOP-1:0], tgl_q};
    end

    // Remember the last synchronized toggle to spot a change.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[TOP];
    end

    assign evt_pulse = chain_q[TOP] ^ prev_q;
endmodule

// File: rtl/card_src_decode.sv
// Module: card_src_decode
// Turns the raw strobes of the interface into one set request per status
// bit and chooses which bits are sticky for the current mode. Assumes
// io_line is already synchronous to clk.
module card_src_decode
    import card_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_mode,
    input  logic            bypass_mode,
    input  logic            t0_mode,
    input  logic            brk_det_en,
    input  logic            wait_tmo,
    input  logic            len_term,
    input  logic            vcc_tmo,
    input  logic            io_line,
    input  logic            tx_empty,
    input  logic            tx_full,
    input  logic            tx_byte_done,
    input  logic            tx_chk_done,
    input  logic            brk_at_end,
    input  logic            tx_brk,
    input  logic            tx_undr,
    input  logic            rx_ovr,
    input  logic            rx_par,
    input  logic            card_pulse,
    output logic [ST_W-1:0] set_vec,
    output logic [ST_W-1:0] sticky
);
    logic io_prev_q;
    logic sent_block;

    // Keep the previous I/O level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) io_prev_q <= 1'b1;
        else        io_prev_q <= io_line;
    end

    // Build the per-bit set requests.
    always_comb begin
        sent_block        = t0_mode & brk_det_en & brk_at_end;
        set_vec           = '0;
        set_vec[B_WAIT]   = sync_mode ? len_term : wait_tmo;
        set_vec[B_CARD]   = card_pulse;
        set_vec[B_VCC]    = vcc_tmo;
        set_vec[B_RDAV]   = bypass_mode & io_prev_q & ~io_line;
        set_vec[B_TXEV]   = tx_empty | tx_full;
        set_vec[B_SENT]   = (tx_byte_done | tx_chk_done) & ~sent_block;
        set_vec[B_TXER]   = tx_brk | tx_undr;
        set_vec[B_RXER]   = rx_ovr | rx_par;
        sticky            = bypass_mode ? STICKY_BYP : STICKY_FIFO;
    end
endmodule

// File: rtl/card_stat_reg.sv
// Module: card_stat_reg
// Holds the status bits. Sticky bits set on request and clear on a read,
// with a same-cycle set taking priority. A non-sticky bit follows the
// supplied level. Assumes clr is a one-cycle read strobe.
module card_stat_reg
    import card_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] set_vec,
    input  logic [ST_W-1:0] sticky,
    input  logic            clr,
    input  logic            lvl_val,
    output logic [ST_W-1:0] stat
);
    for (genvar i = 0; i < ST_W; i++) begin : g_bit
        if (i == B_RDAV) begin : g_lvl
            // Level bit when not sticky, otherwise behaves as the others.
            always_ff @(posedge clk) begin
                if (!rst_n)          stat[i] <= 1'b0;
                else if (!sticky[i]) stat[i] <= lvl_val;
                else                 stat[i] <= set_vec[i] | (stat[i] & ~clr);
            end
        end else begin : g_stk
            // Sticky bit: set wins over a clearing read.
            always_ff @(posedge clk) begin
                if (!rst_n) stat[i] <= 1'b0;
                else        stat[i] <= set_vec[i] | (stat[i] & ~(clr & sticky[i]));
            end
        end
    end
endmodule

// File: rtl/card_irq_hub.sv
// Module: card_irq_hub (top)
// Smart card interface interrupt controller: status register with mixed
// clear rules, enable mask, register bus access and one interrupt output.
// Assumes reg_sel is a one-cycle access strobe and reads are side-effect
// free except at the status address.
module card_irq_hub
    import card_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aon_clk,
    input  logic              aon_rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ST_W-1:0]   reg_wdata,
    output logic [ST_W-1:0]   reg_rdata,
    output logic              irq,
    input  logic              sync_mode,
    input  logic              bypass_mode,
    input  logic              t0_mode,
    input  logic              brk_det_en,
    input  logic              wait_tmo,
    input  logic              len_term,
    input  logic              vcc_tmo,
    input  logic              rx_fifo_nonempty,
    input  logic              io_line,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              tx_byte_done,
    input  logic              tx_chk_done,
    input  logic              brk_at_end,
    input  logic              tx_brk,
    input  logic              tx_undr,
    input  logic              rx_ovr,
    input  logic              rx_par,
    input  logic              card_ins,
    input  logic              card_rem,
    input  logic              card_fault
);
    logic            card_pulse;
    logic [ST_W-1:0] set_vec;
    logic [ST_W-1:0] sticky;
    logic [ST_W-1:0] stat_q;
    logic [ST_W-1:0] en_q;
    logic            rd_clr;
    logic            en_wr;

    assign rd_clr = reg_sel & ~reg_wr & (reg_addr == A_STAT);
    assign en_wr  = reg_sel &  reg_wr & (reg_addr == A_EN);

    card_evt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_card (
        .aon_clk   (aon_clk),
        .aon_rst_n (aon_rst_n),
        .ev_ins    (card_ins),
        .ev_rem    (card_rem),
        .ev_fault  (card_fault),
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (card_pulse)
    );

    card_src_decode u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_mode    (sync_mode),
        .bypass_mode  (bypass_mode),
        .t0_mode      (t0_mode),
        .brk_det_en   (brk_det_en),
        .wait_tmo     (wait_tmo),
        .len_term     (len_term),
        .vcc_tmo      (vcc_tmo),
        .io_line      (io_line),
        .tx_empty     (tx_empty),
        .tx_full      (tx_full),
        .tx_byte_done (tx_byte_done),
        .tx_chk_done  (tx_chk_done),
        .brk_at_end   (brk_at_end),
        .tx_brk       (tx_brk),
        .tx_undr      (tx_undr),
        .rx_ovr       (rx_ovr),
        .rx_par       (rx_par),
        .card_pulse   (card_pulse),
        .set_vec      (set_vec),
        .sticky       (sticky)
    );

    card_stat_reg u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .sticky  (sticky),
        .clr     (rd_clr),
        .lvl_val (rx_fifo_nonempty),
        .stat    (stat_q)
    );

    // Enable mask register, loaded by a bus write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= reg_wdata;
    end

    // Read data mux by address.
    always_comb begin
        reg_rdata = (reg_addr == A_EN) ? en_q : stat_q;
    end

    assign irq = |(stat_q & en_q);
endmodule

// File: rtl/card_irq_chk.sv
// Module: card_irq_chk
// Protocol checks for card_irq_hub, attached through bind below.
module card_irq_chk
    import card_irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            rd_clr,
    input logic            bypass_mode,
    input logic            rx_fifo_nonempty,
    input logic            t0_mode,
    input logic            brk_det_en,
    input logic            brk_at_end,
    input logic            tx_byte_done,
    input logic            tx_chk_done,
    input logic            tx_brk,
    input logic            tx_undr,
    input logic            rx_ovr,
    input logic            rx_par,
    input logic [ST_W-1:0] set_vec,
    input logic [ST_W-1:0] sticky,
    input logic [ST_W-1:0] stat_q,
    input logic [ST_W-1:0] en_q,
    input logic            irq
);
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && set_vec == '0) |=> ((stat_q & $past(sticky)) == '0)); // R2

    AST_RDAV_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass_mode |=> (bypass_mode || stat_q[B_RDAV] == $past(rx_fifo_nonempty))); // R3

    AST_SENT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_q[B_SENT] && t0_mode && brk_det_en && brk_at_end && (tx_byte_done || tx_chk_done))
        |=> !stat_q[B_SENT]); // R6

    AST_TXERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_brk || tx_undr) |=> stat_q[B_TXER]); // R7

    AST_RXERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr || rx_par) |=> stat_q[B_RXER]); // R7

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq); // R8

    AST_SET_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & sticky) != '0) |=>
        ((stat_q & $past(set_vec & sticky)) == $past(set_vec & sticky))); // R9
endmodule

bind card_irq_hub card_irq_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .rd_clr           (rd_clr),
    .bypass_mode      (bypass_mode),
    .rx_fifo_nonempty (rx_fifo_nonempty),
    .t0_mode          (t0_mode),
    .brk_det_en       (brk_det_en),
    .brk_at_end       (brk_at_end),
    .tx_byte_done     (tx_byte_done),
    .tx_chk_done      (tx_chk_done),
    .tx_brk           (tx_brk),
    .tx_undr          (tx_undr),
    .rx_ovr           (rx_ovr),
    .rx_par           (rx_par),
    .set_vec          (set_vec),
    .sticky           (sticky),
    .stat_q           (stat_q),
    .en_q             (en_q),
    .irq              (irq)
);

// File: tb/sim_card_irq_hub.sv
`timescale 1ns/100ps
// Scoreboard bench: read tasks queue expected values, a monitor compares
// them against reg_rdata at the falling edge of each read cycle.
module sim_card_irq_hub;
    localparam int S_WAIT = 0, S_LEN = 1, S_VCC = 2, S_TXE = 3, S_TXF = 4,
                   S_DONE = 5, S_CHK = 6, S_BEND = 7, S_BRK = 8, S_UND = 9,
                   S_OVR = 10, S_PAR = 11;

    logic        clk = 1'b0, aon_clk = 1'b0, clk_run = 1'b1;
    logic        rst_n = 1'b0, aon_rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq;
    logic        sync_mode = 0, bypass_mode = 0, t0_mode = 0, brk_det_en = 0;
    logic        rx_ne = 0, io_line = 1;
    logic [11:0] stb = '0;
    logic        card_ins = 0, card_rem = 0, card_fault = 0;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = clk_run ? ~clk : 1'b0;
    always #15  aon_clk = ~aon_clk;

    card_irq_hub u0 (
        .clk(clk), .rst_n(rst_n), .aon_clk(aon_clk), .aon_rst_n(aon_rst_n),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sync_mode(sync_mode), .bypass_mode(bypass_mode), .t0_mode(t0_mode),
        .brk_det_en(brk_det_en), .wait_tmo(stb[S_WAIT]), .len_term(stb[S_LEN]),
        .vcc_tmo(stb[S_VCC]), .rx_fifo_nonempty(rx_ne), .io_line(io_line),
        .tx_empty(stb[S_TXE]), .tx_full(stb[S_TXF]), .tx_byte_done(stb[S_DONE]),
        .tx_chk_done(stb[S_CHK]), .brk_at_end(stb[S_BEND]), .tx_brk(stb[S_BRK]),
        .tx_undr(stb[S_UND]), .rx_ovr(stb[S_OVR]), .rx_par(stb[S_PAR]),
        .card_ins(card_ins), .card_rem(card_rem), .card_fault(card_fault)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compare each read against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && reg_sel && !reg_wr) begin
            if (exp_q.size() == 0) check("scoreboard empty", reg_rdata, 8'hxx);
            else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic a, input logic [7:0] e, input string tag);
        tick(1);
        exp_q.push_back(e); tag_q.push_back(tag);
        reg_sel = 1; reg_wr = 0; reg_addr = a;
        tick(1);
        reg_sel = 0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        tick(1);
        reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_sel = 0; reg_wr = 0;
    endtask

    task automatic pulse(input logic [11:0] m);
        tick(1);
        stb = m;
        tick(1);
        stb = '0;
    endtask

    task automatic pulse_card(input int which);
        @(posedge aon_clk); #1;
        if (which == 0) card_ins = 1; else if (which == 1) card_rem = 1; else card_fault = 1;
        @(posedge aon_clk); #1;
        card_ins = 0; card_rem = 0; card_fault = 0;
    endtask

    task automatic finish_run;
        if (exp_q.size() != 0) check("scoreboard drained", 8'(exp_q.size()), 8'h00);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge aon_clk);
        #1 rst_n = 1; aon_rst_n = 1;
        // R1 reset state
        tick(1);
        check("R1 irq", {7'b0, irq}, 8'h00);
        rd(0, 8'h00, "R1 status");
        rd(1, 8'h00, "R1 enable");
        // R7 and R11 single sources, R2 clear on read
        pulse(12'(1) << S_BRK); rd(0, 8'h02, "R7 tx break"); rd(0, 8'h00, "R2 cleared");
        pulse(12'(1) << S_UND); rd(0, 8'h02, "R7 underrun");
        pulse(12'(1) << S_OVR); rd(0, 8'h01, "R7 overrun");
        pulse(12'(1) << S_PAR); rd(0, 8'h01, "R7 parity");
        pulse(12'(1) << S_TXE); rd(0, 8'h08, "R7 tx empty");
        pulse(12'(1) << S_TXF); rd(0, 8'h08, "R7 tx full");
        pulse(12'(1) << S_VCC); rd(0, 8'h20, "R7 vcc timer");
        pulse((12'(1) << S_VCC) | (12'(1) << S_PAR) | (12'(1) << S_TXE));
        rd(0, 8'h29, "R11 combined"); rd(0, 8'h00, "R2 all cleared");
        // R5 mode-selected wait timeout
        pulse(12'(1) << S_LEN);  rd(0, 8'h00, "R5 len ignored async");
        pulse(12'(1) << S_WAIT); rd(0, 8'h80, "R5 wait async");
        sync_mode = 1;
        pulse(12'(1) << S_WAIT); rd(0, 8'h00, "R5 wait ignored sync");
        pulse(12'(1) << S_LEN);  rd(0, 8'h80, "R5 len sync");
        sync_mode = 0;
        // R6 byte sent and break suppression
        pulse(12'(1) << S_DONE); rd(0, 8'h04, "R6 byte done");
        pulse(12'(1) << S_CHK);  rd(0, 8'h04, "R6 check byte");
        t0_mode = 1; brk_det_en = 1;
        pulse((12'(1) << S_DONE) | (12'(1) << S_BEND)); rd(0, 8'h00, "R6 suppressed");
        brk_det_en = 0;
        pulse((12'(1) << S_DONE) | (12'(1) << S_BEND)); rd(0, 8'h04, "R6 detect off");
        t0_mode = 0;
        // R3 level-following receive bit
        tick(1); rx_ne = 1;
        rd(0, 8'h10, "R3 fifo data"); rd(0, 8'h10, "R3 read keeps");
        tick(1); rx_ne = 0;
        rd(0, 8'h00, "R3 fifo empty");
        // R4 bypass edge capture
        bypass_mode = 1; rx_ne = 1;
        rd(0, 8'h00, "R4 fifo ignored");
        tick(1); io_line = 0;
        rd(0, 8'h10, "R4 falling edge"); rd(0, 8'h00, "R4 cleared");
        tick(1); io_line = 1; rx_ne = 0;
        rd(0, 8'h00, "R4 rising no set");
        bypass_mode = 0;
        // R8 enable mask and irq
        wr(1, 8'h04); rd(1, 8'h04, "R8 enable rb");
        wr(0, 8'hFF); rd(0, 8'h00, "R8 status write ignored");
        pulse(12'(1) << S_BRK); tick(1);
        check("R8 masked irq", {7'b0, irq}, 8'h00);
        pulse(12'(1) << S_DONE); tick(1);
        check("R8 irq raised", {7'b0, irq}, 8'h01);
        rd(0, 8'h06, "R8 status"); tick(1);
        check("R8 irq cleared", {7'b0, irq}, 8'h00);
        wr(1, 8'h00);
        // R9 event coincident with clearing read
        pulse(12'(1) << S_VCC);
        tick(1);
        exp_q.push_back(8'h20); tag_q.push_back("R9 old value");
        reg_sel = 1; reg_wr = 0; reg_addr = 0; stb = 12'(1) << S_BRK;
        tick(1);
        reg_sel = 0; stb = '0;
        rd(0, 8'h02, "R9 survivor");
        // R10 card events via always-on domain
        pulse_card(1); tick(6); rd(0, 8'h40, "R10 removal");
        pulse_card(2); tick(6); rd(0, 8'h40, "R10 fault");
        @(posedge clk); #1 clk_run = 0;
        pulse_card(0);
        #1 clk_run = 1;
        tick(6); rd(0, 8'h40, "R10 insert clock stopped");
        rd(0, 8'h00, "R10 cleared");
        tick(2);
        done = 1;
        finish_run();
    end
endmodule